// File: doc/BRIEF.md
# Board Control Register Block

This block is a byte-wide register file that a host processor reaches over a small parallel bus. It sits in the board-management logic and exposes fixed revision bytes, two reset-configuration words, a general-purpose output byte, pin-function selects for three shared pin groups and one plain select, a flash boot-bank select and a four-bit high-speed lane routing code. For each shared pin group, the boot bank and the lane routing, a software override bit chooses whether the output comes from the physical switch input or from the register value.

The block also drives the active-low board reset. A write of 1 to the keep-configuration reset register pulses the board reset and leaves every register as it is. A write of 1 to the restore-defaults reset register pulses the board reset and returns every writable register to its power-on value. The boot-bank and lane outputs are captured only while the board reset is low, so a new setting takes hold only through a reset. After power-on the block issues one board-reset pulse by itself, which loads those outputs from the switches.

Top module: `board_ctrl_regs`

## Requirements
- R1: After `rst_ni` is released, `brd_rst_no` stays low until the power-on pulse ends. It is high after at most `RST_CYCLES` cycles. Every writable register then reads its default: override 0x00, config word 1 `CFG1_DEF`, config word 2 `CFG2_DEF`, and 0x00 for all others.
- R2: A read (`cs_i`=1, `we_i`=0) places its data on `rd_data_o` after the next rising edge. The offsets are: 0x00 major revision, 0x01 minor revision, 0x02 board revision (parameters `REV_MAJOR`, `REV_MINOR`, `PCB_REV`), 0x03 keep-configuration reset, 0x04 override, 0x05 config word 1, 0x06 config word 2, 0x07 boot bank, 0x08 general output byte, 0x09 I2C/local-bus select, 0x0A SPI select, 0x0B USB/CAN select, 0x0C LCD/comm-engine select, 0x0D lane routing, 0x0E restore-defaults reset.
- R3: A write to offsets 0x00 to 0x02, or to offset 0x0F and above, changes nothing. A read of offset 0x0F or above returns 0x00.
- R4: Override bit 1 controls the I2C/local-bus group, bit 3 the USB/CAN group and bit 4 the LCD/comm-engine group. When the bit is clear, the group output equals its switch input. When the bit is set, the output equals bit 0 of the group register. In each group register, 0 selects the first function (I2C, USB, LCD) and 1 selects the alternate (local bus, CAN, comm engine). The SPI select output always equals its register.
- R5: The select registers and the boot-bank register keep only bit 0, and the lane register keeps bits 3:0. Their upper bits read as 0. Config words and the general output byte keep all 8 bits and drive `cfg_word1_o`, `cfg_word2_o` and `gpio_o`.
- R6: Writing a value with bit 0 set to offset 0x03 drives `brd_rst_no` low from the cycle after the write edge for exactly `RST_CYCLES` cycles. During the pulse, offset 0x03 reads 0x01. Afterwards it reads 0x00, and every register holds its value.
- R7: Writing a value with bit 0 set to offset 0x0E gives the same pulse, and offset 0x0E reads 0x01 during it. All writable registers return to their R1 defaults on that write edge.
- R8: `boot_bank_o` and `lane_sel_o` change only while `brd_rst_no` is low. During the pulse they take the register value when override bit 6 (bank) or bit 5 (lanes) is set, and the switch input otherwise. Bank 0 is the upper flash bank and 1 is the lower. In the lane code, bit 0 set routes lane B to SGMII (clear: SATA). Bit 1 set routes lane C to PCIe (clear: SGMII). Bit 2 set routes lane D to SGMII (clear: PCIe). Bit 3 set places the first SGMII port on lane B (clear: lane C).
- R9: A reset-register write with bit 0 clear has no effect. A reset-register write made while a pulse is running neither lengthens the pulse nor restores any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| cs_i | input | 1 | Bus select |
| we_i | input | 1 | Write strobe (with cs_i) |
| addr_i | input | 5 | Register offset |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data, one cycle after the request |
| sw_i2c_lbus_i | input | 1 | Switch for the I2C/local-bus group |
| sw_usb_can_i | input | 1 | Switch for the USB/CAN group |
| sw_lcd_comm_i | input | 1 | Switch for the LCD/comm-engine group |
| sw_bank_i | input | 1 | Boot-bank switch |
| sw_lane_i | input | 4 | Lane routing switches |
| brd_rst_no | output | 1 | Active-low board reset |
| mux_i2c_lbus_o | output | 1 | I2C/local-bus group select |
| mux_spi_o | output | 1 | SPI select |
| mux_usb_can_o | output | 1 | USB/CAN group select |
| mux_lcd_comm_o | output | 1 | LCD/comm-engine group select |
| boot_bank_o | output | 1 | Captured boot-bank select |
| lane_sel_o | output | 4 | Captured lane routing code |
| cfg_word1_o | output | 8 | Reset-configuration word 1 |
| cfg_word2_o | output | 8 | Reset-configuration word 2 |
| gpio_o | output | 8 | General output byte |

## Verification
The bench measures the board-reset pulse width and checks it after a reset request has been rewritten during a running pulse. A design that reloads its counter would show a longer pulse. A design that accepts the late restore request would wipe registers the host had set. It writes a new bank and lane setting before any reset and checks that the outputs do not move until a pulse runs. A design that passes registers straight through would switch the flash bank in mid-operation. The bench also checks that the restore-defaults request clears the override byte, so the captured outputs fall back to the switches. Further checks cover all-ones writes to narrow registers, writes to revision and unused offsets, and group outputs under partial override masks. These catch stray storage bits, revision bytes that can be written, and override bits decoded at the wrong position.

// File: rtl/board_ctrl_pkg.sv
package board_ctrl_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned LANE_W = 4;

    // register offsets: software decodes these, so the order is fixed
    localparam int unsigned OFF_REV_MAJ = 'h00;
    localparam int unsigned OFF_REV_MIN = 'h01;
    localparam int unsigned OFF_PCB_REV = 'h02;
    localparam int unsigned OFF_KEEPRST = 'h03;
    localparam int unsigned OFF_OVR     = 'h04;
    localparam int unsigned OFF_CFG1    = 'h05;
    localparam int unsigned OFF_CFG2    = 'h06;
    localparam int unsigned OFF_BANK    = 'h07;
    localparam int unsigned OFF_GPIO    = 'h08;
    localparam int unsigned OFF_I2C     = 'h09;
    localparam int unsigned OFF_SPI     = 'h0A;
    localparam int unsigned OFF_USB     = 'h0B;
    localparam int unsigned OFF_LCD     = 'h0C;
    localparam int unsigned OFF_LANE    = 'h0D;
    localparam int unsigned OFF_INITRST = 'h0E;
    localparam int unsigned OFF_UNUSED  = 'h0F;

    // override bit positions
    localparam int unsigned OVR_I2C  = 1;
    localparam int unsigned OVR_USB  = 3;
    localparam int unsigned OVR_LCD  = 4;
    localparam int unsigned OVR_LANE = 5;
    localparam int unsigned OVR_BANK = 6;

    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_KEEP = 2'd1,
        RK_INIT = 2'd2
    } rst_kind_e;

    typedef struct packed {
        logic [BYTE_W-1:0] ovr;
        logic [BYTE_W-1:0] cfg1;
        logic [BYTE_W-1:0] cfg2;
        logic              bank;
        logic [BYTE_W-1:0] gpio;
        logic              i2c_sel;
        logic              spi_sel;
        logic              usb_sel;
        logic              lcd_sel;
        logic [LANE_W-1:0] lane;
    } ctl_regs_t;

endpackage

// File: rtl/brd_rst_seq.sv
module brd_rst_seq
    import board_ctrl_pkg::*;
#(
    parameter int unsigned RST_CYCLES = 16
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      keep_req_i,
    input  logic      init_req_i,
    output logic      active_o,
    output rst_kind_e kind_o
);
    localparam int unsigned CNT_W = $clog2(RST_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES - 1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
        rst_kind_e        kind;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (seq_q.active) begin
            if (seq_q.cnt == '0) begin
                seq_d.active = 1'b0;
                seq_d.kind   = RK_NONE;
            end else begin
                seq_d.cnt = seq_q.cnt - CNT_W'(1);
            end
        end else if (keep_req_i) begin
            seq_d.active = 1'b1;
            seq_d.cnt    = CNT_LOAD;
            seq_d.kind   = RK_KEEP;
        end else if (init_req_i) begin
            seq_d.active = 1'b1;
            seq_d.cnt    = CNT_LOAD;
            seq_d.kind   = RK_INIT;
        end
    end

    // power-on: start with one pulse already running
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q.active <= 1'b1;
            seq_q.cnt    <= CNT_LOAD;
            seq_q.kind   <= RK_NONE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign active_o = seq_q.active;
    assign kind_o   = seq_q.kind;

    AST_PULSE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.active && seq_q.cnt != '0) |=> seq_q.active); // R6

    AST_NO_RETRIGGER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.active && seq_q.cnt != '0) |=> (seq_q.cnt == $past(seq_q.cnt) - CNT_W'(1))); // R9

    AST_IDLE_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!seq_q.active && !keep_req_i && !init_req_i) |=> !seq_q.active); // R9

endmodule

// File: rtl/brd_regfile.sv
module brd_regfile
    import board_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 5,
    parameter logic [7:0]  REV_MAJOR = 8'h03,
    parameter logic [7:0]  REV_MINOR = 8'h01,
    parameter logic [7:0]  PCB_REV   = 8'h02,
    parameter logic [7:0]  CFG1_DEF  = 8'h14,
    parameter logic [7:0]  CFG2_DEF  = 8'h40
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cs_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              busy_i,
    input  rst_kind_e         kind_i,
    output logic [BYTE_W-1:0] rdata_o,
    output ctl_regs_t         regs_o,
    output logic              keep_req_o,
    output logic              init_req_o
);
    localparam ctl_regs_t REGS_DEF = '{
        ovr: '0, cfg1: CFG1_DEF, cfg2: CFG2_DEF, bank: 1'b0, gpio: '0,
        i2c_sel: 1'b0, spi_sel: 1'b0, usb_sel: 1'b0, lcd_sel: 1'b0, lane: '0
    };

    typedef struct packed {
        ctl_regs_t         r;
        logic [BYTE_W-1:0] rd;
    } rf_t;

    rf_t  rf_d, rf_q;
    logic wr;
    logic restore;

    always_comb begin
        rf_d       = rf_q;
        wr         = cs_i && we_i;
        keep_req_o = wr && (addr_i == ADDR_W'(OFF_KEEPRST)) && wdata_i[0];
        init_req_o = wr && (addr_i == ADDR_W'(OFF_INITRST)) && wdata_i[0];
        restore    = init_req_o && !busy_i;

        if (cs_i && !we_i) begin
            case (addr_i)
                ADDR_W'(OFF_REV_MAJ): rf_d.rd = REV_MAJOR;
                ADDR_W'(OFF_REV_MIN): rf_d.rd = REV_MINOR;
                ADDR_W'(OFF_PCB_REV): rf_d.rd = PCB_REV;
                ADDR_W'(OFF_KEEPRST): rf_d.rd = BYTE_W'(busy_i && kind_i == RK_KEEP);
                ADDR_W'(OFF_OVR):     rf_d.rd = rf_q.r.ovr;
                ADDR_W'(OFF_CFG1):    rf_d.rd = rf_q.r.cfg1;
                ADDR_W'(OFF_CFG2):    rf_d.rd = rf_q.r.cfg2;
                ADDR_W'(OFF_BANK):    rf_d.rd = BYTE_W'(rf_q.r.bank);
                ADDR_W'(OFF_GPIO):    rf_d.rd = rf_q.r.gpio;
                ADDR_W'(OFF_I2C):     rf_d.rd = BYTE_W'(rf_q.r.i2c_sel);
                ADDR_W'(OFF_SPI):     rf_d.rd = BYTE_W'(rf_q.r.spi_sel);
                ADDR_W'(OFF_USB):     rf_d.rd = BYTE_W'(rf_q.r.usb_sel);
                ADDR_W'(OFF_LCD):     rf_d.rd = BYTE_W'(rf_q.r.lcd_sel);
                ADDR_W'(OFF_LANE):    rf_d.rd = BYTE_W'(rf_q.r.lane);
                ADDR_W'(OFF_INITRST): rf_d.rd = BYTE_W'(busy_i && kind_i == RK_INIT);
                default:              rf_d.rd = '0;
            endcase
        end

        if (wr) begin
            case (addr_i)
                ADDR_W'(OFF_OVR):  rf_d.r.ovr     = wdata_i;
                ADDR_W'(OFF_CFG1): rf_d.r.cfg1    = wdata_i;
                ADDR_W'(OFF_CFG2): rf_d.r.cfg2    = wdata_i;
                ADDR_W'(OFF_BANK): rf_d.r.bank    = wdata_i[0];
                ADDR_W'(OFF_GPIO): rf_d.r.gpio    = wdata_i;
                ADDR_W'(OFF_I2C):  rf_d.r.i2c_sel = wdata_i[0];
                ADDR_W'(OFF_SPI):  rf_d.r.spi_sel = wdata_i[0];
                ADDR_W'(OFF_USB):  rf_d.r.usb_sel = wdata_i[0];
                ADDR_W'(OFF_LCD):  rf_d.r.lcd_sel = wdata_i[0];
                ADDR_W'(OFF_LANE): rf_d.r.lane    = wdata_i[LANE_W-1:0];
                default: ;
            endcase
        end

        if (restore) begin
            rf_d.r = REGS_DEF;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rf_q.r  <= REGS_DEF;
            rf_q.rd <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign rdata_o = rf_q.rd;
    assign regs_o  = rf_q.r;

    AST_REV_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cs_i && !we_i && addr_i == ADDR_W'(OFF_REV_MAJ)) |=> (rdata_o == REV_MAJOR)); // R2

    AST_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cs_i && !we_i && addr_i >= ADDR_W'(OFF_UNUSED)) |=> (rdata_o == '0)); // R3

    AST_INIT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (init_req_o && !busy_i) |=> (regs_o.ovr == '0 && regs_o.gpio == '0)); // R7

    AST_KEEP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (keep_req_o && !busy_i) |=> (regs_o == $past(regs_o))); // R6

endmodule

// File: rtl/brd_route.sv
module brd_route
    import board_ctrl_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  ctl_regs_t         regs_i,
    input  logic              active_i,
    input  logic              sw_i2c_i,
    input  logic              sw_usb_i,
    input  logic              sw_lcd_i,
    input  logic              sw_bank_i,
    input  logic [LANE_W-1:0] sw_lane_i,
    output logic              mux_i2c_o,
    output logic              mux_usb_o,
    output logic              mux_lcd_o,
    output logic              bank_o,
    output logic [LANE_W-1:0] lane_o
);
    typedef struct packed {
        logic              bank;
        logic [LANE_W-1:0] lane;
    } cap_t;

    cap_t cap_d, cap_q;
    logic              eff_bank;
    logic [LANE_W-1:0] eff_lane;

    always_comb begin
        eff_bank = regs_i.ovr[OVR_BANK] ? regs_i.bank : sw_bank_i;
        eff_lane = regs_i.ovr[OVR_LANE] ? regs_i.lane : sw_lane_i;
        cap_d    = cap_q;
        if (active_i) begin
            cap_d.bank = eff_bank;
            cap_d.lane = eff_lane;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign mux_i2c_o = regs_i.ovr[OVR_I2C] ? regs_i.i2c_sel : sw_i2c_i;
    assign mux_usb_o = regs_i.ovr[OVR_USB] ? regs_i.usb_sel : sw_usb_i;
    assign mux_lcd_o = regs_i.ovr[OVR_LCD] ? regs_i.lcd_sel : sw_lcd_i;
    assign bank_o    = cap_q.bank;
    assign lane_o    = cap_q.lane;

    AST_CAPTURE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !active_i |=> ($stable(bank_o) && $stable(lane_o))); // R8

endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs
    import board_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W     = 5,
    parameter int unsigned RST_CYCLES = 16,
    parameter logic [7:0]  REV_MAJOR  = 8'h03,
    parameter logic [7:0]  REV_MINOR  = 8'h01,
    parameter logic [7:0]  PCB_REV    = 8'h02,
    parameter logic [7:0]  CFG1_DEF   = 8'h14,
    parameter logic [7:0]  CFG2_DEF   = 8'h40
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cs_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wr_data_i,
    output logic [7:0]        rd_data_o,
    input  logic              sw_i2c_lbus_i,
    input  logic              sw_usb_can_i,
    input  logic              sw_lcd_comm_i,
    input  logic              sw_bank_i,
    input  logic [3:0]        sw_lane_i,
    output logic              brd_rst_no,
    output logic              mux_i2c_lbus_o,
    output logic              mux_spi_o,
    output logic              mux_usb_can_o,
    output logic              mux_lcd_comm_o,
    output logic              boot_bank_o,
    output logic [3:0]        lane_sel_o,
    output logic [7:0]        cfg_word1_o,
    output logic [7:0]        cfg_word2_o,
    output logic [7:0]        gpio_o
);
    ctl_regs_t regs;
    logic      keep_req;
    logic      init_req;
    logic      active;
    rst_kind_e kind;

    brd_regfile #(
        .ADDR_W(ADDR_W), .REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR),
        .PCB_REV(PCB_REV), .CFG1_DEF(CFG1_DEF), .CFG2_DEF(CFG2_DEF)
    ) u_regfile (
        .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .we_i(we_i),
        .addr_i(addr_i), .wdata_i(wr_data_i), .busy_i(active), .kind_i(kind),
        .rdata_o(rd_data_o), .regs_o(regs),
        .keep_req_o(keep_req), .init_req_o(init_req)
    );

    brd_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_rst_seq (
        .clk_i(clk_i), .rst_ni(rst_ni), .keep_req_i(keep_req),
        .init_req_i(init_req), .active_o(active), .kind_o(kind)
    );

    brd_route u_route (
        .clk_i(clk_i), .rst_ni(rst_ni), .regs_i(regs), .active_i(active),
        .sw_i2c_i(sw_i2c_lbus_i), .sw_usb_i(sw_usb_can_i), .sw_lcd_i(sw_lcd_comm_i),
        .sw_bank_i(sw_bank_i), .sw_lane_i(sw_lane_i),
        .mux_i2c_o(mux_i2c_lbus_o), .mux_usb_o(mux_usb_can_o), .mux_lcd_o(mux_lcd_comm_o),
        .bank_o(boot_bank_o), .lane_o(lane_sel_o)
    );

    assign brd_rst_no  = ~active;
    assign mux_spi_o   = regs.spi_sel;
    assign cfg_word1_o = regs.cfg1;
    assign cfg_word2_o = regs.cfg2;
    assign gpio_o      = regs.gpio;

endmodule

// File: tb/board_ctrl_regs_bench.sv
module board_ctrl_regs_bench;
    localparam int unsigned N      = 16;
    localparam logic [7:0]  RMAJ   = 8'h03;
    localparam logic [7:0]  RMIN   = 8'h01;
    localparam logic [7:0]  RPCB   = 8'h02;
    localparam logic [7:0]  C1DEF  = 8'h14;
    localparam logic [7:0]  C2DEF  = 8'h40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, we = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       sw_i2c = 1'b0, sw_usb = 1'b0, sw_lcd = 1'b0, sw_bank = 1'b1;
    logic [3:0] sw_lane = 4'hA;
    logic       brd_rst_n, m_i2c, m_spi, m_usb, m_lcd, bank;
    logic [3:0] lane;
    logic [7:0] cfg1, cfg2, gpio;

    int n_chk = 0;
    int n_fail = 0;
    int run = 0;
    int last_run = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    board_ctrl_regs u_board_ctrl_regs (
        .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .we_i(we), .addr_i(addr),
        .wr_data_i(wdata), .rd_data_o(rdata),
        .sw_i2c_lbus_i(sw_i2c), .sw_usb_can_i(sw_usb), .sw_lcd_comm_i(sw_lcd),
        .sw_bank_i(sw_bank), .sw_lane_i(sw_lane),
        .brd_rst_no(brd_rst_n), .mux_i2c_lbus_o(m_i2c), .mux_spi_o(m_spi),
        .mux_usb_can_o(m_usb), .mux_lcd_comm_o(m_lcd), .boot_bank_o(bank),
        .lane_sel_o(lane), .cfg_word1_o(cfg1), .cfg_word2_o(cfg2), .gpio_o(gpio)
    );

    // length of the most recent completed low phase of the board reset
    always @(negedge clk) begin
        if (!brd_rst_n) run = run + 1;
        else if (run != 0) begin
            last_run = run;
            run = 0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; we = 1'b0;
    endtask

    task automatic bus_rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        cs = 1'b0;
        d = rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] a, input logic [7:0] exp);
        logic [7:0] v;
        bus_rd(a, v);
        chk(tag, 32'(v), 32'(exp));
    endtask

    task automatic wait_release();
        for (int i = 0; i < 4 * N && !brd_rst_n; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 board reset low after power-on", 32'(brd_rst_n), 32'h0);
        wait_release();
        chk("R1 board reset released", 32'(brd_rst_n), 32'h1);
        chk("R8 bank captured from switch", 32'(bank), 32'h1);
        chk("R8 lanes captured from switch", 32'(lane), 32'hA);
        rd_chk("R2 major revision", 5'h00, RMAJ);
        rd_chk("R2 minor revision", 5'h01, RMIN);
        rd_chk("R2 board revision", 5'h02, RPCB);
        rd_chk("R1 override default", 5'h04, 8'h00);
        rd_chk("R1 config word 1 default", 5'h05, C1DEF);
        rd_chk("R1 config word 2 default", 5'h06, C2DEF);
        rd_chk("R1 gpio default", 5'h08, 8'h00);
        rd_chk("R1 lane reg default", 5'h0D, 8'h00);
    endtask

    task automatic t_masking();
        bus_wr(5'h09, 8'hFF);
        rd_chk("R5 i2c select keeps bit 0", 5'h09, 8'h01);
        bus_wr(5'h07, 8'hFE);
        rd_chk("R5 bank keeps bit 0 only", 5'h07, 8'h00);
        bus_wr(5'h0D, 8'hFF);
        rd_chk("R5 lane keeps bits 3:0", 5'h0D, 8'h0F);
        bus_wr(5'h05, 8'hC3);
        chk("R5 config word 1 output", 32'(cfg1), 32'hC3);
        rd_chk("R5 config word 1 readback", 5'h05, 8'hC3);
        bus_wr(5'h06, 8'h3C);
        chk("R5 config word 2 output", 32'(cfg2), 32'h3C);
        bus_wr(5'h08, 8'h96);
        chk("R5 gpio output", 32'(gpio), 32'h96);
        chk("R8 lanes unchanged without reset", 32'(lane), 32'hA);
    endtask

    task automatic t_pinmux();
        bus_wr(5'h09, 8'h00);
        bus_wr(5'h0B, 8'h01);
        bus_wr(5'h0C, 8'h00);
        bus_wr(5'h04, 8'h00);
        sw_i2c = 1'b1; sw_usb = 1'b0; sw_lcd = 1'b1;
        @(negedge clk);
        chk("R4 i2c group follows switch", 32'(m_i2c), 32'h1);
        chk("R4 usb group follows switch", 32'(m_usb), 32'h0);
        chk("R4 lcd group follows switch", 32'(m_lcd), 32'h1);
        bus_wr(5'h04, 8'h08);
        chk("R4 usb group from reg when bit 3 set", 32'(m_usb), 32'h1);
        chk("R4 i2c group still on switch", 32'(m_i2c), 32'h1);
        bus_wr(5'h04, 8'h1A);
        chk("R4 i2c group from reg", 32'(m_i2c), 32'h0);
        chk("R4 lcd group from reg", 32'(m_lcd), 32'h0);
        sw_i2c = 1'b0; sw_lcd = 1'b0;
        bus_wr(5'h09, 8'h01);
        bus_wr(5'h0C, 8'h01);
        chk("R4 i2c alternate from reg", 32'(m_i2c), 32'h1);
        chk("R4 lcd alternate from reg", 32'(m_lcd), 32'h1);
        bus_wr(5'h0A, 8'h01);
        chk("R4 spi select output", 32'(m_spi), 32'h1);
        bus_wr(5'h04, 8'h00);
        chk("R4 i2c back on switch", 32'(m_i2c), 32'h0);
    endtask

    task automatic t_keep_reset();
        bus_wr(5'h08, 8'hA5);
        bus_wr(5'h07, 8'h00);
        bus_wr(5'h0D, 8'h05);
        bus_wr(5'h04, 8'h60);
        @(negedge clk);
        chk("R8 bank unchanged before reset", 32'(bank), 32'h1);
        bus_wr(5'h03, 8'h01);
        chk("R6 board reset asserted", 32'(brd_rst_n), 32'h0);
        rd_chk("R6 request reads 1 during pulse", 5'h03, 8'h01);
        wait_release();
        chk("R6 pulse length", 32'(last_run), 32'(N));
        rd_chk("R6 request self-clears", 5'h03, 8'h00);
        rd_chk("R6 gpio kept", 5'h08, 8'hA5);
        rd_chk("R6 override kept", 5'h04, 8'h60);
        chk("R8 bank from reg after reset", 32'(bank), 32'h0);
        chk("R8 lanes from reg after reset", 32'(lane), 32'h5);
    endtask

    task automatic t_init_reset();
        bus_wr(5'h08, 8'h3C);
        bus_wr(5'h09, 8'h01);
        bus_wr(5'h04, 8'h7A);
        bus_wr(5'h0E, 8'h01);
        chk("R7 board reset asserted", 32'(brd_rst_n), 32'h0);
        rd_chk("R7 request reads 1 during pulse", 5'h0E, 8'h01);
        wait_release();
        chk("R7 pulse length", 32'(last_run), 32'(N));
        rd_chk("R7 request self-clears", 5'h0E, 8'h00);
        rd_chk("R7 gpio restored", 5'h08, 8'h00);
        rd_chk("R7 override restored", 5'h04, 8'h00);
        rd_chk("R7 i2c select restored", 5'h09, 8'h00);
        rd_chk("R7 config word 1 restored", 5'h05, C1DEF);
        chk("R7 bank back to switch", 32'(bank), 32'h1);
        chk("R7 lanes back to switch", 32'(lane), 32'hA);
    endtask

    task automatic t_ignored();
        bus_wr(5'h00, 8'hFF);
        rd_chk("R3 revision write ignored", 5'h00, RMAJ);
        bus_wr(5'h02, 8'h00);
        rd_chk("R3 board revision write ignored", 5'h02, RPCB);
        bus_wr(5'h0F, 8'h55);
        rd_chk("R3 unused offset reads 0", 5'h0F, 8'h00);
        rd_chk("R3 top offset reads 0", 5'h1F, 8'h00);
        bus_wr(5'h03, 8'hFE);
        for (int i = 0; i < 3; i++) begin
            chk("R9 bit0-clear write no pulse", 32'(brd_rst_n), 32'h1);
            @(negedge clk);
        end
        bus_wr(5'h08, 8'h77);
        bus_wr(5'h03, 8'h01);
        repeat (4) @(negedge clk);
        bus_wr(5'h03, 8'h01);
        bus_wr(5'h0E, 8'h01);
        wait_release();
        chk("R9 pulse not lengthened", 32'(last_run), 32'(N));
        rd_chk("R9 late restore ignored", 5'h08, 8'h77);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        t_reset_state();
        t_masking();
        t_pinmux();
        t_keep_reset();
        t_init_reset();
        t_ignored();
        finish_run();
    end

    initial begin
        #(200000 * 10);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule